// File: doc/BRIEF.md
# Injected Conversion Group Sequencer

This block runs the high-priority conversion list of a multi-channel analog-to-digital converter. The list holds up to four ranks. Each rank names a channel and carries an offset, and each channel has its own sampling time. A sequence can start in three ways: a software request, a rising edge on one selected external trigger line, or the completion of the regular conversion group. The block either runs the whole list on each start or, in discontinuous mode, advances one rank per start.

For every rank the block holds a request to a converter core and presents the channel number and that channel's sampling time. When the core answers with a done pulse and a raw code, the block subtracts the rank's offset from the code and stores the signed difference in that rank's result word. When the last rank has been stored, the block sets an end-of-sequence flag and gives a one-cycle pulse.

Top module: `injgrp_sequencer`

## Requirements
- R1: After reset no conversion is requested, `busy` and `eocFlag` are 0, every result word is 0, and the trigger selection is software start (code 7).
- R2: With scan on, one start converts ranks 0 through `seqLenM1` in ascending order. Each rank presents the channel held in its 4-bit field of `rankChans` (rank r at bits 4r+3..4r). `seqLenM1` encodes the list length minus one.
- R3: With scan off, a start converts rank 0 only, whatever `seqLenM1` holds.
- R4: In discontinuous mode (scan on, continuous off), each start converts exactly one rank and then returns to idle. The next start resumes at the following rank. After the last rank, the next start begins again at rank 0.
- R5: `discEn` has no effect when `contEn` is 1 or when scan is off. In that case a start runs the full effective list.
- R6: A `regDone` pulse starts a full sequence when `autoEn` is 1, `discEn` is 0 and the trigger selection is 7. In every other case `regDone` has no effect.
- R7: When the trigger selection s is 0 to 6, only a 0-to-1 transition of `extTrig[s]` starts a sequence. A held high level does not restart it. Edges on other lines and `swStart` have no effect.
- R8: When the trigger selection is 7, a `swStart` pulse starts a sequence and all `extTrig` lines have no effect.
- R9: Each result word (16 bits, rank r at bits 16r+15..16r) receives raw code minus the rank's 12-bit offset (`rankOffsets` bits 12r+11..12r). A raw code below the offset gives a negative two's-complement value.
- R10: One cycle after the last rank of a sequence is captured, `eocFlag` is 1 and `eocPulse` is high for exactly one cycle. `eocFlag` clears when a sequence starts from rank 0.
- R11: A start event that arrives while a conversion is in flight is ignored. The running sequence neither restarts nor repeats.
- R12: A write through `trigSelWr` updates the trigger selection only while `enable` is 0. While `enable` is 1 the write is dropped.
- R13: While a rank is requested, `convSmp` shows the sampling time of the presented channel (channel c at bits 3c+2..3c of `chanSmpTimes`).
- R14: Dropping `enable` removes the request on the next cycle and returns the rank pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 aborts and unlocks trigger selection |
| scanEn | input | 1 | Scan mode: convert more than rank 0 |
| discEn | input | 1 | Discontinuous one-rank-per-start mode |
| contEn | input | 1 | Continuous mode of the converter; overrides discontinuous mode |
| autoEn | input | 1 | Start list automatically after regular group |
| seqLenM1 | input | 2 | List length minus one |
| trigSelIn | input | 3 | Trigger selection to write (7 = software) |
| trigSelWr | input | 1 | Write strobe for trigger selection |
| swStart | input | 1 | Software start request |
| extTrig | input | 7 | External trigger lines |
| regDone | input | 1 | Regular group completion pulse |
| rankChans | input | 16 | Channel number per rank |
| rankOffsets | input | 48 | Offset per rank |
| chanSmpTimes | input | 48 | Sampling time code per channel |
| convReq | output | 1 | Conversion request to core |
| convChan | output | 4 | Channel for current request |
| convSmp | output | 3 | Sampling time for current request |
| convDone | input | 1 | Core done pulse, with valid `convData` |
| convData | input | 12 | Raw code from core |
| rankResults | output | 64 | Signed result word per rank |
| eocFlag | output | 1 | End-of-sequence flag |
| eocPulse | output | 1 | One-cycle end-of-sequence pulse |
| busy | output | 1 | A rank conversion is in flight |

## Verification
The assertions assume that the converter core pulses `convDone` only while `convReq` is high. They also assume that the mode inputs and `seqLenM1` stay fixed while a sequence is in flight or part-way through in discontinuous mode. The bench's core model raises done only after it has observed the request for a latency derived from `convSmp`. The stimulus changes configuration only when the block is idle and the rank pointer is back at rank 0. Before rewriting the trigger selection it lowers `enable`, except in the case that deliberately tests a dropped write.

// File: rtl/injgrp_pkg.sv
package injgrp_pkg;
  localparam int MAX_RANKS = 4;
  localparam int RANK_W    = $clog2(MAX_RANKS);
  localparam int TSEL_W    = 3;
  localparam int NUM_EXT   = (1 << TSEL_W) - 1;
  localparam logic [TSEL_W-1:0] TSEL_SOFT = '1;

  typedef enum logic [0:0] {ST_IDLE, ST_CONV} seqState_e;

  typedef struct packed {
    logic              capture;
    logic [RANK_W-1:0] rank;
  } seqStrobe_t;
endpackage

// File: rtl/injgrp_ctrl.sv
module injgrp_ctrl
  import injgrp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               scanEn,
  input  logic               discEn,
  input  logic               contEn,
  input  logic               autoEn,
  input  logic [RANK_W-1:0]  seqLenM1,
  input  logic [TSEL_W-1:0]  trigSelIn,
  input  logic               trigSelWr,
  input  logic               swStart,
  input  logic [NUM_EXT-1:0] extTrig,
  input  logic               regDone,
  input  logic               convDone,
  output logic               convReq,
  output seqStrobe_t         strobe,
  output logic               eocFlag,
  output logic               eocPulse,
  output logic               busy
);
  logic [TSEL_W-1:0]  trigSel;
  logic [NUM_EXT-1:0] extPrev;
  logic [NUM_EXT:0]   extRiseAll;
  logic               softSel, extHit, discEff, autoEff, trigHit;
  logic               start, capture, isLast;
  logic [RANK_W-1:0]  lastRank, rank;
  seqState_e          state;

  // trigger selection only moves while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       trigSel <= TSEL_SOFT;
    else if (trigSelWr && !enable)    trigSel <= trigSelIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) extPrev <= '0;
    else        extPrev <= extTrig;
  end

  assign extRiseAll = {1'b0, extTrig & ~extPrev};
  assign softSel    = (trigSel == TSEL_SOFT);
  assign extHit     = !softSel && extRiseAll[trigSel];
  assign discEff    = discEn && scanEn && !contEn;
  assign autoEff    = autoEn && !discEn && softSel;
  assign trigHit    = (softSel ? swStart : extHit) || (autoEff && regDone);
  assign lastRank   = scanEn ? seqLenM1 : '0;

  assign start   = enable && (state == ST_IDLE) && trigHit;
  assign capture = (state == ST_CONV) && convDone;
  assign isLast  = (rank >= lastRank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rank     <= '0;
      eocFlag  <= 1'b0;
      eocPulse <= 1'b0;
    end else begin
      eocPulse <= 1'b0;
      if (!enable) begin
        state <= ST_IDLE;
        rank  <= '0;
      end else if (start) begin
        state <= ST_CONV;
        if (rank == '0) eocFlag <= 1'b0;
      end else if (capture) begin
        if (isLast) begin
          rank     <= '0;
          state    <= ST_IDLE;
          eocFlag  <= 1'b1;
          eocPulse <= 1'b1;
        end else begin
          rank <= rank + RANK_W'(1);
          if (discEff) state <= ST_IDLE;
        end
      end
    end
  end

  assign convReq        = (state == ST_CONV);
  assign busy           = (state == ST_CONV);
  assign strobe.capture = capture;
  assign strobe.rank    = rank;

  // R10
  eoc_flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eocPulse |-> eocFlag);

  // R10
  eoc_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eocPulse |=> !eocPulse);

  // R12
  tsel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(trigSel));

  // R11
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_CONV) && !convDone && enable) |=> ((state == ST_CONV) && $stable(rank)));

  // R14
  disable_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!convReq && (rank == '0)));
endmodule

// File: rtl/injgrp_dpath.sv
module injgrp_dpath
  import injgrp_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CH_W  = 4,
  parameter int ST_W  = 3,
  parameter int RES_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  seqStrobe_t                 strobe,
  input  logic [MAX_RANKS*CH_W-1:0]  rankChans,
  input  logic [MAX_RANKS*DW-1:0]    rankOffsets,
  input  logic [(1<<CH_W)*ST_W-1:0]  chanSmpTimes,
  input  logic [DW-1:0]              convData,
  output logic [CH_W-1:0]            convChan,
  output logic [ST_W-1:0]            convSmp,
  output logic [MAX_RANKS*RES_W-1:0] rankResults
);
  logic [DW-1:0]    curOffset;
  logic [RES_W-1:0] diff;

  assign convChan  = rankChans[strobe.rank*CH_W +: CH_W];
  assign convSmp   = chanSmpTimes[convChan*ST_W +: ST_W];
  assign curOffset = rankOffsets[strobe.rank*DW +: DW];
  assign diff      = RES_W'(convData) - RES_W'(curOffset);

  for (genvar r = 0; r < MAX_RANKS; r++) begin : g_rank
    logic [RES_W-1:0] resReg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        resReg <= '0;
      else if (strobe.capture && (strobe.rank == RANK_W'(r)))
        resReg <= diff;
    end
    assign rankResults[r*RES_W +: RES_W] = resReg;
  end

  // R9
  neg_result_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && (convData < curOffset))
      |=> rankResults[$past(strobe.rank)*RES_W + RES_W - 1]);
endmodule

// File: rtl/injgrp_sequencer.sv
module injgrp_sequencer
  import injgrp_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CH_W  = 4,
  parameter int ST_W  = 3,
  parameter int RES_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       scanEn,
  input  logic                       discEn,
  input  logic                       contEn,
  input  logic                       autoEn,
  input  logic [RANK_W-1:0]          seqLenM1,
  input  logic [TSEL_W-1:0]          trigSelIn,
  input  logic                       trigSelWr,
  input  logic                       swStart,
  input  logic [NUM_EXT-1:0]         extTrig,
  input  logic                       regDone,
  input  logic [MAX_RANKS*CH_W-1:0]  rankChans,
  input  logic [MAX_RANKS*DW-1:0]    rankOffsets,
  input  logic [(1<<CH_W)*ST_W-1:0]  chanSmpTimes,
  output logic                       convReq,
  output logic [CH_W-1:0]            convChan,
  output logic [ST_W-1:0]            convSmp,
  input  logic                       convDone,
  input  logic [DW-1:0]              convData,
  output logic [MAX_RANKS*RES_W-1:0] rankResults,
  output logic                       eocFlag,
  output logic                       eocPulse,
  output logic                       busy
);
  seqStrobe_t strobe;

  injgrp_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scanEn(scanEn), .discEn(discEn),
    .contEn(contEn), .autoEn(autoEn), .seqLenM1(seqLenM1), .trigSelIn(trigSelIn),
    .trigSelWr(trigSelWr), .swStart(swStart), .extTrig(extTrig), .regDone(regDone),
    .convDone(convDone), .convReq(convReq), .strobe(strobe), .eocFlag(eocFlag),
    .eocPulse(eocPulse), .busy(busy)
  );

  injgrp_dpath #(.DW(DW), .CH_W(CH_W), .ST_W(ST_W), .RES_W(RES_W)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rankChans(rankChans),
    .rankOffsets(rankOffsets), .chanSmpTimes(chanSmpTimes), .convData(convData),
    .convChan(convChan), .convSmp(convSmp), .rankResults(rankResults)
  );
endmodule

// File: tb/test_injgrp_sequencer.sv
module test_injgrp_sequencer;
  import injgrp_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12, CH_W = 4, ST_W = 3, RES_W = 16;
  localparam int NUM_CH = 1 << CH_W;

  logic clk = 0, rst_n = 0, enable = 0, scanEn = 0, discEn = 0, contEn = 0, autoEn = 0;
  logic [RANK_W-1:0] seqLenM1 = '0;
  logic [TSEL_W-1:0] trigSelIn = '0;
  logic trigSelWr = 0, swStart = 0, regDone = 0;
  logic [NUM_EXT-1:0] extTrig = '0;
  logic [MAX_RANKS*CH_W-1:0] rankChans;
  logic [MAX_RANKS*DW-1:0] rankOffsets;
  logic [NUM_CH*ST_W-1:0] chanSmpTimes;
  logic convReq, convDone = 0, eocFlag, eocPulse, busy;
  logic [CH_W-1:0] convChan;
  logic [ST_W-1:0] convSmp;
  logic [DW-1:0] convData = '0;
  logic [MAX_RANKS*RES_W-1:0] rankResults;

  logic [CH_W-1:0] chanCfg [MAX_RANKS] = '{4'd5, 4'd9, 4'd2, 4'd14};
  logic [DW-1:0]   offCfg  [MAX_RANKS] = '{12'h010, 12'h000, 12'hFFF, 12'h123};

  for (genvar r = 0; r < MAX_RANKS; r++) begin : g_cfg
    assign rankChans[r*CH_W +: CH_W] = chanCfg[r];
    assign rankOffsets[r*DW +: DW]   = offCfg[r];
  end
  for (genvar c = 0; c < NUM_CH; c++) begin : g_smp
    assign chanSmpTimes[c*ST_W +: ST_W] = ST_W'(c % 8);
  end

  injgrp_sequencer i_injgrp_sequencer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int rank;
    logic [CH_W-1:0] chan;
    logic [ST_W-1:0] smp;
    logic [RES_W-1:0] res;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t got;
  int checks = 0, fails = 0, salt = 0, eocCount = 0, lat = 0;
  logic [CH_W-1:0] lastChan = '0;
  logic [ST_W-1:0] lastSmp = '0;

  function automatic void check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic logic [DW-1:0] rawOf(logic [CH_W-1:0] ch);
    return DW'((int'(ch) * 251 + 100 + salt * 37) % 4096);
  endfunction

  // converter core model and scoreboard monitor
  always @(negedge clk) begin
    if (convDone) begin
      if (expQ.size() == 0) check(0, "R11", "unexpected conversion", longint'(lastChan), 0);
      else begin
        got = expQ.pop_front();
        check(lastChan == got.chan, "R2", "channel order", longint'(lastChan), longint'(got.chan));
        check(lastSmp == got.smp, "R13", "sampling time", longint'(lastSmp), longint'(got.smp));
        check(rankResults[got.rank*RES_W +: RES_W] == got.res, "R9", "result word",
              longint'(rankResults[got.rank*RES_W +: RES_W]), longint'(got.res));
      end
    end
    if (eocPulse) eocCount++;
    convDone = 0;
    if (convReq && rst_n) begin
      if (lat >= 2 + int'(convSmp)) begin
        convDone = 1;
        convData = rawOf(convChan);
        lastChan = convChan;
        lastSmp  = convSmp;
        lat = 0;
      end else lat++;
    end else lat = 0;
  end

  // driver side: push expected item for a rank
  task automatic pushExp(int r);
    expItem_t e;
    e.rank = r;
    e.chan = chanCfg[r];
    e.smp  = ST_W'(int'(chanCfg[r]) % 8);
    e.res  = RES_W'(rawOf(chanCfg[r])) - RES_W'(offCfg[r]);
    expQ.push_back(e);
  endtask

  task automatic waitIdle(string req);
    int n = 0;
    repeat (3) @(negedge clk);
    while ((busy || expQ.size() != 0) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, req, "pending conversions", expQ.size(), 0);
  endtask

  task automatic pulseSw();
    @(negedge clk) swStart = 1;
    @(negedge clk) swStart = 0;
  endtask

  task automatic pulseExt(int s);
    @(negedge clk) extTrig[s] = 1;
    @(negedge clk) extTrig[s] = 0;
  endtask

  task automatic writeSel(logic [TSEL_W-1:0] v);
    @(negedge clk) begin trigSelIn = v; trigSelWr = 1; end
    @(negedge clk) trigSelWr = 0;
  endtask

  task automatic runFull(string req, int n);
    int e0 = eocCount;
    salt++;
    for (int r = 0; r < n; r++) pushExp(r);
    pulseSw();
    waitIdle(req);
    check(eocCount == e0 + 1, req, "eoc pulses", eocCount - e0, 1);
    check(eocFlag == 1, "R10", "eoc flag", eocFlag, 1);
  endtask

  task automatic quietCheck(string req, int e0);
    repeat (30) @(negedge clk);
    check(!busy && eocCount == e0, req, "no sequence started", eocCount - e0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "WATCHDOG", "run timed out", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(!convReq && !busy, "R1", "idle after reset", convReq, 0);
    check(eocFlag == 0, "R1", "eoc flag after reset", eocFlag, 0);
    check(rankResults == '0, "R1", "results after reset", longint'(rankResults), 0);
    enable = 1;

    // R2 full list of four, rank 2 gives a negative result (R9)
    scanEn = 1; seqLenM1 = 2'd3;
    runFull("R2", 4);
    check(rankResults[2*RES_W + RES_W-1] == 1, "R9", "negative sign", rankResults[2*RES_W + RES_W-1], 1);
    // R1: default selection is software start
    check(eocCount == 1, "R1", "software start default", eocCount, 1);

    // R3 scan off converts rank 0 only
    scanEn = 0;
    runFull("R3", 1);

    // R2 shorter list
    scanEn = 1; seqLenM1 = 2'd1;
    runFull("R2", 2);

    // R4 discontinuous
    discEn = 1; seqLenM1 = 2'd2; salt++;
    for (int s = 0; s < 3; s++) begin
      e0 = eocCount;
      pushExp(s);
      pulseSw();
      waitIdle("R4");
      check(eocCount - e0 == (s == 2 ? 1 : 0), "R4", "eoc per step", eocCount - e0, s == 2 ? 1 : 0);
    end
    pushExp(0);
    pulseSw();
    waitIdle("R4");
    check(eocFlag == 0, "R10", "flag cleared at new start", eocFlag, 0);
    for (int s = 1; s < 3; s++) begin
      pushExp(s);
      pulseSw();
      waitIdle("R4");
    end
    check(eocFlag == 1, "R4", "wrap completes", eocFlag, 1);

    // R5 discontinuous overridden
    contEn = 1;
    runFull("R5", 3);
    contEn = 0; scanEn = 0;
    runFull("R5", 1);
    scanEn = 1; discEn = 0;

    // R6 auto start after regular group
    autoEn = 1; seqLenM1 = 2'd1;
    e0 = eocCount; salt++;
    pushExp(0); pushExp(1);
    @(negedge clk) regDone = 1;
    @(negedge clk) regDone = 0;
    waitIdle("R6");
    check(eocCount == e0 + 1, "R6", "auto sequence", eocCount - e0, 1);
    discEn = 1; e0 = eocCount;
    @(negedge clk) regDone = 1;
    @(negedge clk) regDone = 0;
    quietCheck("R6", e0);
    discEn = 0; autoEn = 0; e0 = eocCount;
    @(negedge clk) regDone = 1;
    @(negedge clk) regDone = 0;
    quietCheck("R6", e0);

    // R12 write while enabled is dropped; R8 external ignored under software
    writeSel(3'd2);
    e0 = eocCount;
    pulseExt(2);
    quietCheck("R8", e0);
    runFull("R12", 2);

    // R7 external trigger select
    enable = 0;
    writeSel(3'd2);
    enable = 1;
    e0 = eocCount;
    pulseSw();
    quietCheck("R7", e0);
    pulseExt(5);
    quietCheck("R7", e0);
    salt++;
    pushExp(0); pushExp(1);
    @(negedge clk) extTrig[2] = 1;
    waitIdle("R7");
    repeat (40) @(negedge clk);
    check(eocCount == e0 + 1, "R7", "held level no restart", eocCount - e0, 1);
    extTrig[2] = 0;

    // R11 start while running ignored
    enable = 0;
    writeSel(3'd7);
    enable = 1; seqLenM1 = 2'd3;
    e0 = eocCount; salt++;
    for (int r = 0; r < 4; r++) pushExp(r);
    pulseSw();
    repeat (10) @(negedge clk);
    pulseSw();
    waitIdle("R11");
    repeat (20) @(negedge clk);
    check(eocCount == e0 + 1, "R11", "single sequence", eocCount - e0, 1);

    // R14 disable aborts
    pulseSw();
    while (!convReq) @(negedge clk);
    enable = 0;
    @(negedge clk);
    check(!convReq, "R14", "request dropped", convReq, 0);
    enable = 1;
    runFull("R14", 4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule